// File: doc/BRIEF.md
# Step-wise Division Unit

This block performs a 32-bit by 32-bit division one step per command. The step commands are a setup step, an iteration step and three final correction steps. The dividend is written into the low result register MDL. The divisor is presented on an input and held steady for the whole sequence. When the sequence completes, MDL holds the quotient and the high register MDH holds the remainder. Two flags, Z and C, describe the partial remainder and the outcome of the most recent trial subtraction.

An unsigned divide is the unsigned setup step followed by 32 iteration steps. A signed divide is the signed setup step, 32 iteration steps, then correction step 2, correction step 3 and the final step 4, in that order. The signed setup step replaces the dividend with its magnitude and records the sign of each operand. The iterations then work on magnitudes. Step 2 sets the flags from the remainder. Step 3 gives a nonzero remainder the sign of the dividend. Step 4 negates the quotient when the operand signs differ.

Each iteration occupies the unit for a parameterised number of cycles. A built-in sequencer can issue a complete sequence on its own, and is meant for testing.

Top module: `stepdiv_unit`

## Requirements
- R1: Commands are encoded on `cmd` as 0 none, 1 signed setup, 2 unsigned setup, 3 iteration, 4 correction step 2, 5 correction step 3 and 6 final step 4. A command is taken when `cmd_valid` is high and `busy` is low. The unsigned setup step clears MDH and leaves MDL unchanged.
- R2: The signed setup step sets MDH to zero and replaces MDL with the magnitude of its two's-complement value.
- R3: An iteration shifts the 64-bit pair MDH:MDL left by one and compares the shifted upper part against the divisor. The divisor is taken as its magnitude after a signed setup. When the divisor fits, it is subtracted, the new MDL bit 0 is 1 and C is 0. Otherwise MDH keeps the shifted value, the new bit is 0 and C is 1. Z is 1 when the resulting MDH is zero. After an unsigned setup and 32 iterations, MDL equals the unsigned quotient and MDH equals the remainder. With a zero divisor the result is quotient 0xFFFFFFFF and remainder equal to the dividend.
- R4: After the full signed sequence, MDL holds the quotient truncated toward zero and MDH holds a remainder with the sign of the dividend. Dividing 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R5: The setup steps, step 3 and step 4 leave Z and C unchanged. Step 2 sets Z when MDH is zero, and sets C when the dividend was negative and MDH is nonzero. After a full signed sequence, therefore, Z shows a zero remainder and C shows a negative remainder.
- R6: A taken iteration holds `busy` high for ITER_CYCLES-1 cycles (default ITER_CYCLES = 2), during which MDL is unchanged. Its result appears at the clock edge where `busy` falls. Every other step completes at the edge where it is taken.
- R7: Commands and register writes presented while `busy` is high have no effect.
- R8: After reset, MDH, MDL, Z, C, `busy` and `seq_active` are all 0.
- R9: A pulse on `seq_go` while the unit is idle makes the sequencer run a complete divide on the current MDL and divisor. The divide is signed when `seq_signed` is 1. While `seq_active` is high, external commands and writes are ignored. The result is complete once both `seq_active` and `busy` are low.
- R10: When the unit is idle and no command is presented, `md_wr_lo` loads `md_wdata` into MDL and `md_wr_hi` loads it into MDH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Step command present |
| cmd | input | 3 | Step command code |
| divisor | input | 32 | Divisor operand, held during a divide |
| md_wr_lo | input | 1 | Write `md_wdata` into MDL |
| md_wr_hi | input | 1 | Write `md_wdata` into MDH |
| md_wdata | input | 32 | Register write data |
| seq_go | input | 1 | Start the built-in sequencer |
| seq_signed | input | 1 | Sequencer runs a signed divide |
| mdh | output | 32 | High register (remainder) |
| mdl | output | 32 | Low register (quotient) |
| flag_z | output | 1 | Zero partial remainder flag |
| flag_c | output | 1 | Failed subtraction / negative remainder flag |
| busy | output | 1 | Iteration in progress |
| seq_active | output | 1 | Sequencer running |

## Verification
Random operand pairs are divided both through hand-issued commands and through the sequencer, in both signed and unsigned mode, and are compared against a bench model of truncating division. Directed cases cover the most negative dividend over minus one, a zero divisor, a zero dividend, a divisor of one, and every combination of operand signs. The sign combinations separate the remainder-sign correction from the quotient negation. Commands and writes are injected during busy cycles and during a sequencer run, so a design that does not ignore them yields a wrong result. Separate checks observe the busy window and the intermediate register values after each setup step.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;

    parameter int DATA_W = 32;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_SETUP_S = 3'd1,
        CMD_SETUP_U = 3'd2,
        CMD_ITER    = 3'd3,
        CMD_CORR2   = 3'd4,
        CMD_CORR3   = 3'd5,
        CMD_FIN4    = 3'd6
    } step_cmd_e;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } md_pair_t;

    typedef struct packed {
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic sgn;
        logic neg_dd;
        logic neg_dv;
    } sign_ctx_t;

    typedef struct packed {
        md_pair_t md;
        flags_t   fl;
    } iter_res_t;

    function automatic logic [DATA_W-1:0] mag(input logic [DATA_W-1:0] v);
        return v[DATA_W-1] ? (~v + 1'b1) : v;
    endfunction

    // One restoring step: shift the pair left, try the subtraction, keep it if no borrow.
    function automatic iter_res_t iter_step(input md_pair_t m, input logic [DATA_W-1:0] dv);
        logic [DATA_W:0]   sh;
        logic [DATA_W+1:0] diff;
        logic              borrow;
        iter_res_t         r;
        sh     = {m.hi, m.lo[DATA_W-1]};
        diff   = {1'b0, sh} - {2'b00, dv};
        borrow = diff[DATA_W+1];
        r.md.hi = borrow ? sh[DATA_W-1:0] : diff[DATA_W-1:0];
        r.md.lo = {m.lo[DATA_W-2:0], ~borrow};
        r.fl.c  = borrow;
        r.fl.z  = (r.md.hi == '0);
        return r;
    endfunction

endpackage

// File: rtl/stepdiv_alu.sv
module stepdiv_alu
    import stepdiv_pkg::*;
(
    input  step_cmd_e         cmd_i,
    input  md_pair_t          md_i,
    input  flags_t            fl_i,
    input  sign_ctx_t         ctx_i,
    input  logic [DATA_W-1:0] div_i,
    output md_pair_t          md_o,
    output flags_t            fl_o,
    output sign_ctx_t         ctx_o
);
    logic [DATA_W-1:0] eff_div;
    iter_res_t         it;
    logic              rem_nz;

    assign eff_div = ctx_i.sgn ? mag(div_i) : div_i;
    assign it      = iter_step(md_i, eff_div);
    assign rem_nz  = (md_i.hi != '0);

    always_comb begin
        md_o  = md_i;
        fl_o  = fl_i;
        ctx_o = ctx_i;
        case (cmd_i)
            CMD_SETUP_S: begin
                ctx_o.sgn    = 1'b1;
                ctx_o.neg_dd = md_i.lo[DATA_W-1];
                ctx_o.neg_dv = div_i[DATA_W-1];
                md_o.lo      = mag(md_i.lo);
                md_o.hi      = '0;
            end
            CMD_SETUP_U: begin
                ctx_o   = '0;
                md_o.hi = '0;
            end
            CMD_ITER: begin
                md_o = it.md;
                fl_o = it.fl;
            end
            CMD_CORR2: begin
                fl_o.z = ~rem_nz;
                fl_o.c = ctx_i.sgn & ctx_i.neg_dd & rem_nz;
            end
            CMD_CORR3: begin
                if (ctx_i.sgn && ctx_i.neg_dd && rem_nz)
                    md_o.hi = ~md_i.hi + 1'b1;
            end
            CMD_FIN4: begin
                if (ctx_i.sgn && (ctx_i.neg_dd ^ ctx_i.neg_dv))
                    md_o.lo = ~md_i.lo + 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stepdiv_seq.sv
module stepdiv_seq
    import stepdiv_pkg::*;
#(
    parameter int ITERS = DATA_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      go_i,
    input  logic      signed_i,
    input  logic      core_busy_i,
    output logic      active_o,
    output logic      valid_o,
    output step_cmd_e cmd_o
);
    localparam int LAST_S = ITERS + 3;
    localparam int IDX_W  = $clog2(LAST_S + 1);

    logic [IDX_W-1:0] idx;
    logic             run;
    logic             sgn;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = sgn ? IDX_W'(LAST_S) : IDX_W'(ITERS);
    assign active_o = run;
    assign valid_o  = run & ~core_busy_i;

    always_comb begin
        if (idx == '0)
            cmd_o = sgn ? CMD_SETUP_S : CMD_SETUP_U;
        else if (idx <= IDX_W'(ITERS))
            cmd_o = CMD_ITER;
        else if (idx == IDX_W'(ITERS + 1))
            cmd_o = CMD_CORR2;
        else if (idx == IDX_W'(ITERS + 2))
            cmd_o = CMD_CORR3;
        else
            cmd_o = CMD_FIN4;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            sgn <= 1'b0;
            idx <= '0;
        end else if (!run) begin
            if (go_i && !core_busy_i) begin
                run <= 1'b1;
                sgn <= signed_i;
                idx <= '0;
            end
        end else if (valid_o) begin
            if (idx == last_idx)
                run <= 1'b0;
            else
                idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/stepdiv_unit.sv
module stepdiv_unit
    import stepdiv_pkg::*;
#(
    parameter int ITER_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd,
    input  logic [DATA_W-1:0] divisor,
    input  logic              md_wr_lo,
    input  logic              md_wr_hi,
    input  logic [DATA_W-1:0] md_wdata,
    input  logic              seq_go,
    input  logic              seq_signed,
    output logic [DATA_W-1:0] mdh,
    output logic [DATA_W-1:0] mdl,
    output logic              flag_z,
    output logic              flag_c,
    output logic              busy,
    output logic              seq_active
);
    localparam int  CNT_W     = (ITER_CYCLES > 1) ? $clog2(ITER_CYCLES) : 1;
    localparam bit  MULTI_CYC = (ITER_CYCLES > 1);

    md_pair_t   md_q, md_n;
    flags_t     fl_q, fl_n;
    sign_ctx_t  ctx_q, ctx_n;
    logic [CNT_W-1:0] cnt;

    logic       seq_valid;
    step_cmd_e  seq_cmd;
    logic       step_valid;
    step_cmd_e  step_cmd;
    logic       accept;
    logic       commit_iter;
    logic       defer_iter;
    step_cmd_e  alu_cmd;
    logic       wr_ok;

    stepdiv_seq #(.ITERS(DATA_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .go_i        (seq_go),
        .signed_i    (seq_signed),
        .core_busy_i (busy),
        .active_o    (seq_active),
        .valid_o     (seq_valid),
        .cmd_o       (seq_cmd)
    );

    assign step_valid  = seq_active ? seq_valid : cmd_valid;
    assign step_cmd    = seq_active ? seq_cmd : step_cmd_e'(cmd);
    assign busy        = (cnt != '0);
    assign accept      = step_valid & ~busy;
    assign commit_iter = MULTI_CYC && (cnt == CNT_W'(1));
    assign defer_iter  = MULTI_CYC && accept && (step_cmd == CMD_ITER);
    assign wr_ok       = ~busy & ~step_valid & ~seq_active;

    always_comb begin
        if (commit_iter)
            alu_cmd = CMD_ITER;
        else if (accept && !defer_iter)
            alu_cmd = step_cmd;
        else
            alu_cmd = CMD_NOP;
    end

    stepdiv_alu u_alu (
        .cmd_i (alu_cmd),
        .md_i  (md_q),
        .fl_i  (fl_q),
        .ctx_i (ctx_q),
        .div_i (divisor),
        .md_o  (md_n),
        .fl_o  (fl_n),
        .ctx_o (ctx_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            md_q  <= '0;
            fl_q  <= '0;
            ctx_q <= '0;
            cnt   <= '0;
        end else begin
            md_q  <= md_n;
            fl_q  <= fl_n;
            ctx_q <= ctx_n;
            if (busy)
                cnt <= cnt - 1'b1;
            else if (defer_iter)
                cnt <= CNT_W'(ITER_CYCLES - 1);
            if (wr_ok && md_wr_lo)
                md_q.lo <= md_wdata;
            if (wr_ok && md_wr_hi)
                md_q.hi <= md_wdata;
        end
    end

    assign mdh    = md_q.hi;
    assign mdl    = md_q.lo;
    assign flag_z = fl_q.z;
    assign flag_c = fl_q.c;
endmodule

// File: rtl/stepdiv_chk.sv
module stepdiv_chk
    import stepdiv_pkg::*;
#(
    parameter int ITER_CYCLES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              step_valid,
    input step_cmd_e         step_cmd,
    input logic              busy,
    input logic [DATA_W-1:0] mdh,
    input logic [DATA_W-1:0] mdl,
    input logic              flag_z,
    input logic              flag_c,
    input logic              seq_active
);
    logic taken;
    assign taken = step_valid && !busy;

    p_setup_u_clears_r1: assert property (@(posedge clk) disable iff (rst)
        (taken && step_cmd == CMD_SETUP_U) |=> (mdh == '0 && $stable(mdl)));

    p_setup_s_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (taken && step_cmd == CMD_SETUP_S) |=> (mdh == '0 && !mdl[DATA_W-1] || mdl == {1'b1, {(DATA_W-1){1'b0}}}));

    p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (taken && (step_cmd == CMD_SETUP_S || step_cmd == CMD_SETUP_U ||
                   step_cmd == CMD_CORR3 || step_cmd == CMD_FIN4))
        |=> ($stable(flag_z) && $stable(flag_c)));

    p_corr2_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (taken && step_cmd == CMD_CORR2) |=> (flag_z == (mdh == '0)));

    p_iter_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (taken && step_cmd == CMD_ITER && ITER_CYCLES > 1) |=> (busy && $stable(mdl)));

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(mdl) && $stable(mdh)));

    p_reset_r8: assert property (@(posedge clk)
        $past(rst) |-> (mdh == '0 && mdl == '0 && !busy && !seq_active && !flag_z && !flag_c));
endmodule

bind stepdiv_unit stepdiv_chk #(.ITER_CYCLES(ITER_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_valid (step_valid),
    .step_cmd   (step_cmd),
    .busy       (busy),
    .mdh        (mdh),
    .mdl        (mdl),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .seq_active (seq_active)
);

// File: tb/stepdiv_unit_test.sv
`timescale 1ns/1ps
module stepdiv_unit_test;
    localparam int W  = 32;
    localparam int IC = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd = 3'd0;
    logic [W-1:0] divisor = '0;
    logic         md_wr_lo = 1'b0, md_wr_hi = 1'b0;
    logic [W-1:0] md_wdata = '0;
    logic         seq_go = 1'b0, seq_signed = 1'b0;
    logic [W-1:0] mdh, mdl;
    logic         flag_z, flag_c, busy, seq_active;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    stepdiv_unit #(.ITER_CYCLES(IC)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .divisor(divisor),
        .md_wr_lo(md_wr_lo), .md_wr_hi(md_wr_hi), .md_wdata(md_wdata),
        .seq_go(seq_go), .seq_signed(seq_signed), .mdh(mdh), .mdl(mdl),
        .flag_z(flag_z), .flag_c(flag_c), .busy(busy), .seq_active(seq_active)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected quotient, remainder, Z and C from the requirements
    function automatic logic [2*W+1:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input bit sg);
        logic [W-1:0] q, r;
        logic z, c;
        if (!sg) begin
            if (b == 0) begin q = '1; r = a; end
            else begin q = a / b; r = a % b; end
            z = (r == 0);
            c = ~q[0];
        end else begin
            if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin q = a; r = 0; end
            else begin q = $signed(a) / $signed(b); r = $signed(a) % $signed(b); end
            z = (r == 0);
            c = r[W-1];
        end
        return {q, r, z, c};
    endfunction

    task automatic write_md(input logic [W-1:0] lo, input logic [W-1:0] hi);
        @(negedge clk);
        md_wr_lo = 1'b1; md_wr_hi = 1'b1; md_wdata = lo;
        @(negedge clk);
        md_wr_lo = 1'b1; md_wr_hi = 1'b0; md_wdata = lo;
        md_wr_hi = 1'b0;
        md_wr_lo = 1'b0;
        // first cycle wrote lo into both; now overwrite hi with garbage
        md_wr_hi = 1'b1; md_wdata = hi;
        @(negedge clk);
        md_wr_hi = 1'b0;
    endtask

    task automatic issue(input logic [2:0] c, input bit inject);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c;
        @(negedge clk);
        if (inject && busy) begin
            cmd = 3'd2; md_wr_lo = 1'b1; md_wr_hi = 1'b1; md_wdata = $urandom;
            @(negedge clk);
            md_wr_lo = 1'b0; md_wr_hi = 1'b0;
        end
        cmd_valid = 1'b0; cmd = 3'd0;
        while (busy) @(negedge clk);
    endtask

    task automatic run_manual(input logic [W-1:0] a, input logic [W-1:0] b, input bit sg, input bit inject, input string tag);
        logic [2*W+1:0] e;
        divisor = b;
        write_md(a, $urandom);
        issue(sg ? 3'd1 : 3'd2, 1'b0);
        for (int i = 0; i < W; i++) issue(3'd3, inject);
        if (sg) begin
            issue(3'd4, 1'b0); issue(3'd5, 1'b0); issue(3'd6, 1'b0);
        end
        e = model(a, b, sg);
        chk({tag, " quotient"},  mdl, e[2*W+1:W+2]);
        chk({tag, " remainder"}, mdh, e[W+1:2]);
        chk({tag, " flagZ"}, {31'd0, flag_z}, {31'd0, e[1]});
        chk({tag, " flagC"}, {31'd0, flag_c}, {31'd0, e[0]});
    endtask

    task automatic run_seq(input logic [W-1:0] a, input logic [W-1:0] b, input bit sg, input string tag);
        logic [2*W+1:0] e;
        divisor = b;
        write_md(a, $urandom);
        @(negedge clk);
        seq_go = 1'b1; seq_signed = sg;
        @(negedge clk);
        seq_go = 1'b0;
        cmd_valid = 1'b1; cmd = 3'd2; md_wr_lo = 1'b1; md_wdata = 32'hDEAD_BEEF;
        while (seq_active || busy) @(negedge clk);
        cmd_valid = 1'b0; cmd = 3'd0; md_wr_lo = 1'b0;
        e = model(a, b, sg);
        chk({tag, " quotient"},  mdl, e[2*W+1:W+2]);
        chk({tag, " remainder"}, mdh, e[W+1:2]);
        chk({tag, " flagZ"}, {31'd0, flag_z}, {31'd0, e[1]});
        chk({tag, " flagC"}, {31'd0, flag_c}, {31'd0, e[0]});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] a, b, keep_lo;
        bit fz, fc;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 mdh reset", mdh, '0);
        chk("R8 mdl reset", mdl, '0);
        chk("R8 flags/busy/seq reset", {28'd0, flag_z, flag_c, busy, seq_active}, '0);

        // R10 writes and R1 unsigned setup
        write_md(32'h1357_9BDF, 32'hCAFE_F00D);
        chk("R10 write lo", mdl, 32'h1357_9BDF);
        chk("R10 write hi", mdh, 32'hCAFE_F00D);
        fz = flag_z; fc = flag_c;
        issue(3'd2, 1'b0);
        chk("R1 setup_u clears mdh", mdh, '0);
        chk("R1 setup_u keeps mdl", mdl, 32'h1357_9BDF);
        chk("R5 setup_u keeps flags", {30'd0, flag_z, flag_c}, {30'd0, fz, fc});

        // R6 iteration latency
        divisor = 32'd3;
        keep_lo = mdl;
        @(negedge clk); cmd_valid = 1'b1; cmd = 3'd3;
        @(negedge clk); cmd_valid = 1'b0; cmd = 3'd0;
        chk("R6 busy during iteration", {31'd0, busy}, 32'd1);
        chk("R6 mdl held while busy", mdl, keep_lo);
        @(negedge clk);
        chk("R6 busy released", {31'd0, busy}, 32'd0);
        chk("R6 mdl shifted after commit", mdl, {keep_lo[30:0], 1'b0});
        chk("R3 shifted remainder", mdh, 32'd0);
        chk("R3 C on failed subtraction", {31'd0, flag_c}, 32'd1);

        // R2 signed setup
        divisor = 32'd7;
        write_md(32'hFFFF_FFF0, 32'h5555_5555);
        issue(3'd1, 1'b0);
        chk("R2 signed setup magnitude", mdl, 32'd16);
        chk("R2 signed setup mdh", mdh, '0);

        // Directed corners
        run_manual(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R4 min/-1");
        run_manual(32'd100, 32'd0, 1'b0, 1'b0, "R3 zero divisor");
        run_manual(32'd0, 32'd9, 1'b0, 1'b0, "R3 zero dividend");
        run_manual(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R3 divide by one");
        run_manual(32'd47, 32'd5, 1'b1, 1'b0, "R4 pos/pos");
        run_manual(-32'sd47, 32'd5, 1'b1, 1'b0, "R4 neg/pos");
        run_manual(32'd47, -32'sd5, 1'b1, 1'b0, "R4 pos/neg");
        run_manual(-32'sd47, -32'sd5, 1'b1, 1'b0, "R5 neg/neg");
        run_manual(-32'sd45, 32'd5, 1'b1, 1'b0, "R5 neg exact");

        // R7 injected commands while busy
        for (int i = 0; i < 6; i++) begin
            a = $urandom; b = $urandom >> ($urandom % 28);
            if (b == 0) b = 1;
            run_manual(a, b, i[0], 1'b1, "R7 inject");
        end

        // Random manual sequences
        for (int i = 0; i < 24; i++) begin
            a = $urandom; b = $urandom >> ($urandom % 30);
            if (b == 0) b = 3;
            if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) b = 5;
            run_manual(a, b, i[0], 1'b0, i[0] ? "R4 random signed" : "R3 random unsigned");
        end

        // R9 sequencer
        run_seq(32'd1000, 32'd7, 1'b0, "R9 seq unsigned");
        run_seq(-32'sd1000, 32'd7, 1'b1, "R9 seq signed");
        for (int i = 0; i < 8; i++) begin
            a = $urandom; b = $urandom >> ($urandom % 30);
            if (b == 0) b = 11;
            run_seq(a, b, i[0], "R9 seq random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule